// File: doc/BRIEF.md
# Iterative 32-bit Feistel block cipher engine

This block encrypts or decrypts one 32-bit block with an 80-bit key. It runs 32 rounds, one per clock. It does not hold the key itself. On every cycle of a run it drives a round index, and a companion generator must answer on the same cycle with the 16-bit subkey for that round. The S-box and the two 16-bit bit permutations are parameters, so the same engine can take other tables.

A run begins with a one-cycle start strobe that is sampled while the engine is idle. The encrypt/decrypt select is latched with it. The engine stays busy for 32 cycles. It then raises a one-cycle completion pulse, and the output register holds the result until the next run completes.

The round works on a left half L (bits 31:16) and a right half R (bits 15:0). R is rotated left by 7. Each nibble goes through the S-box. The result is XORed with L and with the subkey, and the sum goes through permutation PR to give the next R. R itself goes through permutation PL to give the next L. Decryption runs the exact inverse of this round and walks the subkeys in reverse order.

Top module: `feistel32_core`

## Requirements
- R1: After reset, busy, done, result and round_idx are all zero.
- R2: A start sampled while busy is low loads din into the state and latches dec_sel. Busy rises at that clock edge, and exactly 32 rounds follow. Done is high in the cycle after the 32nd round edge, which is 32 clock edges after the start edge, and busy is low in that same cycle.
- R3: One encryption round computes next L = PL(R) and next R = PR(L ^ S(rotl7(R)) ^ subkey). Here rotl7 rotates the 16-bit half left by 7 bit positions.
- R4: S applies one 4-bit substitution to each nibble independently and keeps nibble order: output bits [4n+3:4n] are the S-box image of input bits [4n+3:4n]. The S-box image of value v is the 4-bit field at bits [63-4v -: 4] of SBOX_MAP. The default map, for inputs 0 to F, is 6,4,C,5,0,7,2,E,1,F,3,D,8,A,9,B.
- R5: In a permutation table, the entry for output position j sits at bits [63-4j -: 4] and holds a source position s. Positions are counted from the leftmost bit (bit 15) starting at 0, so output bit 15-j takes input bit 15-s. The default PR entries are (5j+3) mod 16 (64'h38D27C16B05AF49E). The default PL entries are (3j+7) mod 16 (64'h7AD0369CF258BE14). Neither default has a fixed point.
- R6: With dec_sel high, the engine applies the inverse round. Decrypting a ciphertext under the same subkey provider returns the original plaintext.
- R7: While busy, round_idx counts 0 to 31 for encryption and 31 down to 0 for decryption. Round i consumes the subkey presented while round_idx equals i.
- R8: Done is high for exactly one cycle per run. The result holds its value from one completion until the next.
- R9: A start asserted while busy is high is ignored. The round sequence and the result of the run in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| dec_sel | input | 1 | 1 = decrypt, 0 = encrypt; latched with start |
| din | input | 32 | Input block |
| subkey | input | 16 | Subkey for the round currently shown on round_idx |
| round_idx | output | 5 | Round whose subkey is requested |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 32 | Result block |

## Verification
Round_idx is due in the cycle after the start edge, and it steps once per edge after that. The bench checks it at every falling edge of a run. Done and the result are due exactly 32 rising edges after the start edge, so the bench counts those edges and samples at the falling edge that follows. It checks one edge later that done has dropped. An independent arithmetic model in the bench supplies the expected ciphertext for a sweep of blocks and keys. Every ciphertext is then run back through decryption, and a start pulse placed in mid-run must leave the result of that run unchanged.

// File: rtl/feistel32_core.sv
module feistel32_core #(
  parameter int          ROUNDS   = 32,
  parameter int          ROT      = 7,
  parameter logic [63:0] SBOX_MAP = 64'h64C5_072E_1F3D_8A9B,
  parameter logic [63:0] PERM_R   = 64'h38D2_7C16_B05A_F49E,
  parameter logic [63:0] PERM_L   = 64'h7AD0_369C_F258_BE14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dec_sel,
  input  logic [31:0] din,
  input  logic [15:0] subkey,
  output logic [4:0]  round_idx,
  output logic        busy,
  output logic        done,
  output logic [31:0] dout
);

  localparam int CW = $clog2(ROUNDS);
  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

  function automatic logic [15:0] permute(input logic [15:0] x, input logic [63:0] t);
    logic [15:0] o;
    for (int j = 0; j < 16; j++) o[15-j] = x[15 - int'(t[63-4*j -: 4])];
    return o;
  endfunction

  function automatic logic [63:0] invert(input logic [63:0] t);
    logic [63:0] o;
    o = '0;
    for (int j = 0; j < 16; j++) o[63 - 4*int'(t[63-4*j -: 4]) -: 4] = 4'(j);
    return o;
  endfunction

  function automatic logic [15:0] rotl(input logic [15:0] x);
    return (x << ROT) | (x >> (16 - ROT));
  endfunction

  function automatic logic [15:0] subst(input logic [15:0] x);
    logic [15:0] o;
    for (int n = 0; n < 4; n++) o[4*n +: 4] = SBOX_MAP[63 - 4*int'(x[4*n +: 4]) -: 4];
    return o;
  endfunction

  localparam logic [63:0] INV_R = invert(PERM_R);
  localparam logic [63:0] INV_L = invert(PERM_L);

  logic [31:0]   st_q;
  logic [CW-1:0] cnt_q;
  logic          dec_q;

  wire [15:0] hl = st_q[31:16];
  wire [15:0] hr = st_q[15:0];

  wire [15:0] enc_l = permute(hr, PERM_L);
  wire [15:0] enc_r = permute(hl ^ subst(rotl(hr)) ^ subkey, PERM_R);
  wire [15:0] dec_r = permute(hl, INV_L);
  wire [15:0] dec_l = permute(hr, INV_R) ^ subst(rotl(dec_r)) ^ subkey;

  wire [31:0] nxt = dec_q ? {dec_l, dec_r} : {enc_l, enc_r};

  assign round_idx = 5'(dec_q ? LAST - cnt_q : cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      cnt_q <= '0;
      dec_q <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      dout  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st_q  <= din;
          cnt_q <= '0;
          dec_q <= dec_sel;
          busy  <= 1'b1;
        end
      end else begin
        st_q  <= nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          dout <= nxt;
        end
      end
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && round_idx == (dec_q ? 5'(LAST) : 5'd0)));

  // R2
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      (round_idx == (dec_q ? $past(round_idx) - 5'd1 : $past(round_idx) + 5'd1)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && round_idx != (dec_q ? 5'd0 : 5'(LAST))) |=> (busy && $stable(dec_q)));

endmodule

// File: tb/feistel32_core_tb.sv
module feistel32_core_tb;
  localparam logic [63:0] SB = 64'h64C5_072E_1F3D_8A9B;
  localparam logic [63:0] PR = 64'h38D2_7C16_B05A_F49E;
  localparam logic [63:0] PL = 64'h7AD0_369C_F258_BE14;

  logic clk = 0, rst_n = 0, start = 0, dec_sel = 0;
  logic [31:0] din = '0;
  logic [15:0] seed = '0;
  logic [15:0] subkey;
  logic [4:0] round_idx;
  logic busy, done;
  logic [31:0] dout;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] kfn(input logic [4:0] r, input logic [15:0] s);
    logic [15:0] v;
    v = s ^ (16'(r) * 16'h9E37);
    return {v[10:0], v[15:11]} ^ {11'd0, r};
  endfunction
  assign subkey = kfn(round_idx, seed);

  feistel32_core u_dut (.clk, .rst_n, .start, .dec_sel, .din, .subkey,
                        .round_idx, .busy, .done, .dout);

  function automatic logic [15:0] m_perm(input logic [15:0] x, input logic [63:0] t);
    logic [15:0] o;
    for (int j = 0; j < 16; j++) o[15-j] = x[15 - int'(t[63-4*j -: 4])];
    return o;
  endfunction

  function automatic logic [15:0] m_f(input logic [15:0] r, input logic [15:0] k);
    logic [15:0] x, o;
    x = {r[8:0], r[15:9]};
    for (int n = 0; n < 4; n++) o[4*n +: 4] = SB[63 - 4*int'(x[4*n +: 4]) -: 4];
    return o ^ k;
  endfunction

  function automatic logic [31:0] m_enc(input logic [31:0] p, input logic [15:0] s);
    logic [15:0] l, r, t;
    l = p[31:16]; r = p[15:0];
    for (int i = 0; i < 32; i++) begin
      t = m_perm(l ^ m_f(r, kfn(5'(i), s)), PR);
      l = m_perm(r, PL);
      r = t;
    end
    return {l, r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] blk, input bit dec, input logic [31:0] exp,
                     input bit poke, output logic [31:0] res);
    din = blk; dec_sel = dec; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 32; i++) begin
      chk(busy == 1'b1, "R2", 32'(busy), 1);
      chk(round_idx == (dec ? 5'(31 - i) : 5'(i)), "R7", 32'(round_idx), dec ? 31 - i : i);
      if (poke && i == 10) begin
        start = 1; din = ~blk; dec_sel = ~dec;
      end
      @(negedge clk);
      start = 0;
    end
    chk(done == 1'b1 && busy == 1'b0, "R2", {30'd0, done, busy}, 32'h2);
    chk(dout == exp, poke ? "R9" : (dec ? "R6" : "R3"), dout, exp);
    res = dout;
    @(negedge clk);
    chk(done == 1'b0, "R8", 32'(done), 0);
    chk(dout == exp, "R8", dout, exp);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ct, pt, e;
    repeat (3) @(negedge clk);
    chk({busy, done, round_idx} == 7'd0 && dout == 0, "R1", {busy, done, round_idx, dout[24:0]}, 0);
    rst_n = 1;
    @(negedge clk);
    // R4 R5: zero block, zero seed exercises S-box image of 0 and the tables
    e = m_enc(32'h0, 16'h0);
    run(32'h0, 0, e, 0, ct);
    for (int v = 0; v < 96; v++) begin
      seed = 16'(v * 16'h3B1D + 7);
      pt = {16'(v * 16'h1F3) ^ 16'hA5C3, 16'(v) << (v % 13)};
      if (v % 16 == 0) pt = 32'h1 << (v / 16);
      e = m_enc(pt, seed);
      run(pt, 0, e, 0, ct);
      run(ct, 1, pt, 0, pt);
    end
    // R9: start in mid-run ignored
    seed = 16'hBEEF;
    e = m_enc(32'hDEAD_0001, seed);
    run(32'hDEAD_0001, 0, e, 1, ct);
    run(ct, 1, 32'hDEAD_0001, 1, pt);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule